// File: doc/BRIEF.md
# Serial Clock Mode Auto-Selector

This block decides how the serial input of an audio converter is clocked. One input pin does double duty: it carries either a bit clock from outside the chip, or a static level that asks for de-emphasis. The block runs on the master clock. It samples the shared pin and the frame clock (the left/right word clock) through synchronisers, counts rising edges on the shared pin, and chooses between two modes. In external mode the pin is the shift clock. In internal mode a local generator drives the shift clock and the pin's level is read as the de-emphasis request.

The decision has hysteresis and follows the frame clock. A burst of at least `ENTER_EDGES` pin rising edges inside one half of a frame clock period selects external mode. `EXIT_FRAMES` complete frames with no pin rising edge return the block to internal mode. A mode change only takes effect at a frame clock edge, so the shift clock is never swapped in the middle of a word. The internal clock generator, the data shift register and the de-emphasis filter are outside this block. It drives only the mode flag, a shift clock steering select and the qualified de-emphasis enable.

Top module: `sclk_mode_sel`

## Requirements
- R1: After reset the block is in internal mode, and `ext_mode_o`, `shift_sel_o` and `deemph_en_o` are all 0. The edge and idle-frame counts are cleared.
- R2: When at least `ENTER_EDGES` rising edges of the synchronised pin fall within a single frame clock phase (high or low), the block enters external mode (`ext_mode_o` = 1) at the frame clock edge that closes that phase.
- R3: A phase with fewer than `ENTER_EDGES` pin rising edges does not cause entry. The count restarts at every frame clock edge, so edges in different phases are never added together.
- R4: `ext_mode_o` changes only as the result of a frame clock edge. It stays steady for the rest of the phase and takes its new value within `SYNC_STAGES` + 2 master clock cycles after the frame clock edge.
- R5: A frame is one frame clock period that starts at a rising edge. In external mode the block returns to internal mode at the frame clock rising edge that completes the `EXIT_FRAMES`-th consecutive frame with no pin rising edge, and not at any earlier one.
- R6: Any pin rising edge, including a single static low-to-high step, restarts the idle-frame count. A frame that contains one does not count as idle.
- R7: In internal mode `deemph_en_o` follows the synchronised pin level (1 = de-emphasis on).
- R8: In external mode `deemph_en_o` is 0 whatever the pin level.
- R9: `shift_sel_o` selects the shift clock source: 1 = the external pin, 0 = the internal generator. It always equals `ext_mode_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; all state is clocked on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| lrck_i | input | 1 | Frame (left/right word) clock, synchronous to clk |
| dpin_i | input | 1 | Shared pin: external bit clock or static de-emphasis level |
| ext_mode_o | output | 1 | 1 = external serial clock mode, 0 = internal mode |
| shift_sel_o | output | 1 | Shift clock steering: 1 = pin, 0 = internal generator |
| deemph_en_o | output | 1 | De-emphasis enable, forced 0 in external mode |

## Verification
The bench builds the block with `ENTER_EDGES` = 4 and `EXIT_FRAMES` = 2. At these values every burst size from zero to past the threshold fits in one short frame clock phase. The sweep therefore hits the exact entry boundary, one edge below it, and bursts split across a frame clock edge, in both high and low phases. The small exit count also makes every idle-frame case short enough to try, including a return to internal mode exactly on the second clean frame, a restart by a single static pin step, and both de-emphasis states in each mode. Each expected value comes from an arithmetic model of the phase counts, checked a few cycles after each frame clock edge and again at the end of each phase.

// File: rtl/smsel_pkg.sv
package smsel_pkg;

  typedef enum logic {
    MODE_INT = 1'b0,
    MODE_EXT = 1'b1
  } ser_mode_e;

  function automatic int cnt_width(input int max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction

endpackage

// File: rtl/smsel_sync.sv
module smsel_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= '0;
      else     chain[s] <= chain[s-1];
    end
  end

  assign q_o = chain[STAGES-1];

endmodule

// File: rtl/smsel_edges.sv
module smsel_edges (
  input  logic clk,
  input  logic rst,
  input  logic lr_s_i,
  input  logic pin_s_i,
  output logic lr_edge_o,
  output logic lr_rise_o,
  output logic pin_rise_o
);

  logic lr_d;
  logic pin_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      lr_d  <= 1'b0;
      pin_d <= 1'b0;
    end else begin
      lr_d  <= lr_s_i;
      pin_d <= pin_s_i;
    end
  end

  assign lr_edge_o  = lr_s_i ^ lr_d;
  assign lr_rise_o  = lr_s_i & ~lr_d;
  assign pin_rise_o = pin_s_i & ~pin_d;

endmodule

// File: rtl/smsel_phase_cnt.sv
module smsel_phase_cnt #(
  parameter int ENTER_EDGES = 16,
  localparam int ECW = smsel_pkg::cnt_width(ENTER_EDGES)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           lr_edge_i,
  input  logic           pin_rise_i,
  output logic [ECW-1:0] ecnt_o,
  output logic           enter_hit_o
);

  localparam logic [ECW-1:0] LIMIT = ECW'(ENTER_EDGES);

  logic [ECW-1:0] ecnt;

  // The count is for one phase only: a frame clock edge starts a fresh count.
  // A pin edge seen in the same cycle as that edge counts for the new phase.
  always_ff @(posedge clk) begin
    if (rst) begin
      ecnt <= '0;
    end else if (lr_edge_i) begin
      ecnt <= pin_rise_i ? ECW'(1) : '0;
    end else if (pin_rise_i && (ecnt != LIMIT)) begin
      ecnt <= ecnt + ECW'(1);
    end
  end

  assign ecnt_o      = ecnt;
  assign enter_hit_o = lr_edge_i && (ecnt == LIMIT);

endmodule

// File: rtl/smsel_idle_cnt.sv
module smsel_idle_cnt #(
  parameter int EXIT_FRAMES = 2,
  localparam int FCW = smsel_pkg::cnt_width(EXIT_FRAMES)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           lr_rise_i,
  input  logic           pin_rise_i,
  output logic [FCW-1:0] fcnt_o,
  output logic           exit_hit_o
);

  localparam logic [FCW-1:0] LIMIT = FCW'(EXIT_FRAMES);
  localparam logic [FCW-1:0] LAST  = FCW'(EXIT_FRAMES - 1);

  logic [FCW-1:0] fcnt;
  logic           seen;
  logic           frame_clean;

  assign frame_clean = lr_rise_i && !seen && !pin_rise_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      fcnt <= '0;
      seen <= 1'b0;
    end else if (lr_rise_i) begin
      seen <= pin_rise_i;
      if (!frame_clean)        fcnt <= '0;
      else if (fcnt != LIMIT)  fcnt <= fcnt + FCW'(1);
    end else if (pin_rise_i) begin
      seen <= 1'b1;
      fcnt <= '0;
    end
  end

  assign fcnt_o     = fcnt;
  assign exit_hit_o = frame_clean && (fcnt >= LAST);

endmodule

// File: rtl/sclk_mode_sel.sv
module sclk_mode_sel #(
  parameter int SYNC_STAGES = 2,
  parameter int ENTER_EDGES = 16,
  parameter int EXIT_FRAMES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic lrck_i,
  input  logic dpin_i,
  output logic ext_mode_o,
  output logic shift_sel_o,
  output logic deemph_en_o
);

  import smsel_pkg::*;

  localparam int ECW = cnt_width(ENTER_EDGES);
  localparam int FCW = cnt_width(EXIT_FRAMES);

  logic [1:0]     raw_in;
  logic [1:0]     syn_in;
  logic           lr_s;
  logic           pin_s;
  logic           lr_edge;
  logic           lr_rise;
  logic           pin_rise;
  logic [ECW-1:0] ecnt;
  logic [FCW-1:0] fcnt;
  logic           enter_hit;
  logic           exit_hit;
  ser_mode_e      mode_q;
  ser_mode_e      mode_d;
  logic           shift_q;
  logic           deemph_q;

  assign raw_in = {lrck_i, dpin_i};

  smsel_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (raw_in),
    .q_o (syn_in)
  );

  assign lr_s  = syn_in[1];
  assign pin_s = syn_in[0];

  smsel_edges u_edges (
    .clk        (clk),
    .rst        (rst),
    .lr_s_i     (lr_s),
    .pin_s_i    (pin_s),
    .lr_edge_o  (lr_edge),
    .lr_rise_o  (lr_rise),
    .pin_rise_o (pin_rise)
  );

  smsel_phase_cnt #(.ENTER_EDGES(ENTER_EDGES)) u_phase (
    .clk         (clk),
    .rst         (rst),
    .lr_edge_i   (lr_edge),
    .pin_rise_i  (pin_rise),
    .ecnt_o      (ecnt),
    .enter_hit_o (enter_hit)
  );

  smsel_idle_cnt #(.EXIT_FRAMES(EXIT_FRAMES)) u_idle (
    .clk        (clk),
    .rst        (rst),
    .lr_rise_i  (lr_rise),
    .pin_rise_i (pin_rise),
    .fcnt_o     (fcnt),
    .exit_hit_o (exit_hit)
  );

  // Both hit strobes can only be high in a cycle with a frame clock edge,
  // so the mode can only move at a word boundary. Entry wins a tie.
  always_comb begin
    mode_d = mode_q;
    if (enter_hit)                         mode_d = MODE_EXT;
    else if (exit_hit && mode_q == MODE_EXT) mode_d = MODE_INT;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= MODE_INT;
      shift_q  <= 1'b0;
      deemph_q <= 1'b0;
    end else begin
      mode_q   <= mode_d;
      shift_q  <= (mode_d == MODE_EXT);
      deemph_q <= (mode_d == MODE_INT) && pin_s;
    end
  end

  assign ext_mode_o  = (mode_q == MODE_EXT);
  assign shift_sel_o = shift_q;
  assign deemph_en_o = deemph_q;

endmodule

// File: rtl/smsel_checker.sv
module smsel_checker #(
  parameter int ENTER_EDGES = 16,
  parameter int EXIT_FRAMES = 2,
  localparam int ECW = smsel_pkg::cnt_width(ENTER_EDGES),
  localparam int FCW = smsel_pkg::cnt_width(EXIT_FRAMES)
) (
  input logic           clk,
  input logic           rst,
  input logic           lr_edge,
  input logic           lr_rise,
  input logic [ECW-1:0] ecnt,
  input logic [FCW-1:0] fcnt,
  input logic           ext_mode_o,
  input logic           deemph_en_o
);

  p_reset_internal_r1: assert property (@(posedge clk)
    $past(rst) |-> !ext_mode_o && !deemph_en_o);

  p_enter_at_threshold_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(ext_mode_o) |-> ($past(ecnt) == ECW'(ENTER_EDGES)));

  p_count_bounded_r3: assert property (@(posedge clk) disable iff (rst)
    ecnt <= ECW'(ENTER_EDGES));

  p_switch_on_lr_edge_r4: assert property (@(posedge clk) disable iff (rst)
    !$stable(ext_mode_o) |-> $past(lr_edge));

  p_exit_after_idle_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(ext_mode_o) |-> $past(lr_rise) && ($past(fcnt) >= FCW'(EXIT_FRAMES - 1)));

  p_deemph_masked_r8: assert property (@(posedge clk) disable iff (rst)
    ext_mode_o |-> !deemph_en_o);

endmodule

bind sclk_mode_sel smsel_checker #(
  .ENTER_EDGES (ENTER_EDGES),
  .EXIT_FRAMES (EXIT_FRAMES)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .lr_edge     (lr_edge),
  .lr_rise     (lr_rise),
  .ecnt        (ecnt),
  .fcnt        (fcnt),
  .ext_mode_o  (ext_mode_o),
  .deemph_en_o (deemph_en_o)
);

// File: tb/tb_sclk_mode_sel.sv
module tb_sclk_mode_sel;

  localparam int E  = 4;
  localparam int X  = 2;
  localparam int PH = 48;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lrck = 1'b0;
  logic pin = 1'b0;
  logic ext_mode, shift_sel, deemph;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench model of the mode decision
  bit exp_ext = 1'b0;
  int idle_f = 0;
  bit seen_f = 1'b0;
  int last_rises = 0;

  always #10 clk = ~clk;

  sclk_mode_sel #(.SYNC_STAGES(2), .ENTER_EDGES(E), .EXIT_FRAMES(X)) dut (
    .clk         (clk),
    .rst         (rst),
    .lrck_i      (lrck),
    .dpin_i      (pin),
    .ext_mode_o  (ext_mode),
    .shift_sel_o (shift_sel),
    .deemph_en_o (deemph)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all(input string tag_mode);
    check(tag_mode, ext_mode, exp_ext);
    check("R9 shift_sel", shift_sel, exp_ext);
    check(exp_ext ? "R8 deemph masked" : "R7 deemph follows pin", deemph, !exp_ext && pin);
  endtask

  // One frame clock phase: toggle the frame clock, then either hold the
  // pin at a static level or give it n rising pulses.
  task automatic phase(input int n, input logic stat);
    int rises;
    bit ent;
    @(negedge clk);
    lrck = ~lrck;
    ent = (last_rises >= E);
    if (ent) exp_ext = 1'b1;
    if (lrck) begin
      if (seen_f) idle_f = 0;
      else if (idle_f < X) idle_f++;
      seen_f = 1'b0;
      if (!ent && exp_ext && idle_f >= X) exp_ext = 1'b0;
    end
    rises = 0;
    if (n == 0) begin
      if (stat && !pin) rises = 1;
      pin = stat;
    end else begin
      pin = 1'b0;
    end
    repeat (6) @(negedge clk);
    check("R2/R5 mode after lrck edge", ext_mode, exp_ext);
    check("R9 shift_sel", shift_sel, exp_ext);
    check(exp_ext ? "R8 deemph masked" : "R7 deemph follows pin", deemph, !exp_ext && pin);
    for (int k = 0; k < n; k++) begin
      pin = 1'b1; repeat (2) @(negedge clk);
      pin = 1'b0; repeat (2) @(negedge clk);
      rises++;
    end
    repeat (PH - 7 - 4 * n) @(negedge clk);
    if (rises > 0) begin
      seen_f = 1'b1;
      idle_f = 0;
    end
    last_rises = rises;
    check_all("R4 mode steady within phase");
  endtask

  task automatic settle_internal();
    for (int k = 0; k < 8; k++) begin
      if (!exp_ext && last_rises == 0) break;
      phase(0, 1'b0);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check("R1 reset mode", ext_mode, 1'b0);
    check("R1 reset shift_sel", shift_sel, 1'b0);
    check("R1 reset deemph", deemph, 1'b0);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    check("R1 mode after release", ext_mode, 1'b0);

    // R2/R3: sweep burst sizes through and past the threshold, both phases
    for (int n = 0; n <= E + 2; n++) begin
      phase(n, 1'b0);
      settle_internal();
      phase(0, 1'b0);
      phase(n, 1'b0);
      settle_internal();
    end

    // R3: bursts just below the threshold on each side of an lrck edge
    phase(E - 1, 1'b0);
    phase(E - 1, 1'b0);
    phase(0, 1'b0);
    check("R3 split bursts not summed", ext_mode, 1'b0);

    // R7: static de-emphasis levels in internal mode
    phase(0, 1'b1);
    phase(0, 1'b1);
    phase(0, 1'b0);

    // R8/R6: enter, then a static high step in external mode
    phase(E, 1'b0);
    phase(0, 1'b0);
    check("R2 entered", ext_mode, 1'b1);
    phase(0, 1'b1);
    phase(0, 1'b1);
    phase(0, 1'b1);
    phase(0, 1'b0);
    // R6: one lone edge late in the idle wait restarts the count
    phase(0, 1'b1);
    phase(0, 1'b0);
    phase(0, 1'b0);
    phase(1, 1'b0);
    for (int k = 0; k < 7; k++) phase(0, 1'b0);
    check("R5 back to internal", ext_mode, 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule